// File: doc/BRIEF.md
# Serial-Loaded DAC Code and Mode Register Front End

This block is the digital front end of a single-channel voltage-output converter. A host writes it through a three-wire serial link: an active-low select/load line, a serial clock and a serial data line. The three serial lines are brought into the block's own clock domain by a synchronizer. Serial clock edges are found by edge detection, and bits are gathered into a 24-bit shift register. When the select line returns high, the block decodes the 4-bit command at the top of the frame. That command acts on an input (staging) register, the DAC register that drives the converter, a power-down flag and a reference-select flag.

A frame has 24 bits: the command, four bits that are ignored, and a 16-bit data word that holds the code left-justified. A host that works in bytes may send 32 bits, with eight leading filler bits that are dropped. Frames of any other length are discarded. The resolution (8, 10 or 12 bits) and the reset code (zero or mid-scale) are parameters.

The serial inputs are plain pins with no handshake. The outputs are levels that change only in the cycle after a frame is accepted. No stream interface exists, so no back-pressure applies.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset the input and DAC registers hold zero (MID_RESET=0) or 2^(RES-1) (MID_RESET=1), power-down is clear and the internal reference is selected (ref_supply=0).
- R2: Command 4'b0000 (frame bits 23:20) loads the input register only. dac_code and both flags stay as they were.
- R3: Command 4'b0001 copies the input register to dac_code and clears power-down. The data word is ignored.
- R4: Command 4'b0011 loads the new code into both the input register and dac_code, and clears power-down.
- R5: Command 4'b0100 sets pwr_down and leaves both code registers unchanged.
- R6: Command 4'b0110 sets ref_supply=0 and 4'b0111 sets ref_supply=1. Neither changes the codes or power-down.
- R7: A 32-bit frame is executed as the 24-bit frame formed by its last 24 bits; the first 8 bits are dropped. The serial clock may idle high or low when select falls.
- R8: A frame runs only if exactly 24 or 32 serial clock rising edges were seen while select was low. Any other count leaves all state unchanged. Rising edges while select is high are not counted.
- R9: Reserved command codes (every value other than 0,1,3,4,6,7) change nothing.
- R10: The code is data-word bits 15 down to 16-RES (frame bits 15 down to 16-RES). The lower data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Active-low select; its rising edge executes the frame |
| spi_sck | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_sdi | input | 1 | Serial data, most significant bit first |
| dac_code | output | RES | DAC register contents |
| pwr_down | output | 1 | High while the converter is powered down |
| ref_supply | output | 1 | 1 = supply used as reference, 0 = internal reference |

## Verification
Each command is sent with data words whose low padding bits are set. This separates correct left-justification from an off-by-one field slice, and shows that the data is ignored on non-write commands. Frames are sent in 24-bit and 32-bit form, with the serial clock idling both high and low. Truncated and overlong frames (16, 23, 25, 31, 33 bits), reserved codes and stray clock edges outside a frame are also sent. Together these separate the length gate and the bit-dropping from the decode. Random command streams then mix power-down with write-only and update commands, so a flag or register update that reaches the wrong command shows up as a mismatch with the model.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_BITS  = 24;
  localparam int PREFIX_BITS = 8;
  localparam int LONG_BITS   = FRAME_BITS + PREFIX_BITS;
  localparam int WORD_BITS   = 16;

  typedef enum logic [3:0] {
    OP_LOAD_IN   = 4'h0,
    OP_COMMIT    = 4'h1,
    OP_LOAD_BOTH = 4'h3,
    OP_SLEEP     = 4'h4,
    OP_REF_INT   = 4'h6,
    OP_REF_SUP   = 4'h7
  } op_e;

  typedef struct packed {
    logic [3:0]           op;
    logic [3:0]           pad;
    logic [WORD_BITS-1:0] word;
  } frame_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   csn_s,
  input  logic   sck_s,
  input  logic   sdi_s,
  output frame_t frame,
  output logic   exec_go
);
  localparam int CNT_W = $clog2(LONG_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(LONG_BITS);

  logic                  csn_d, sck_d;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  sck_rise, csn_rise, csn_fall;

  assign sck_rise = sck_s & ~sck_d;
  assign csn_rise = csn_s & ~csn_d;
  assign csn_fall = ~csn_s & csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_d   <= 1'b1;
      sck_d   <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
      exec_go <= 1'b0;
    end else begin
      csn_d   <= csn_s;
      sck_d   <= sck_s;
      exec_go <= csn_rise && (bit_cnt == CNT_SHORT || bit_cnt == CNT_LONG);
      if (csn_fall) begin
        bit_cnt <= '0;
      end else if (!csn_s && sck_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], sdi_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign frame = frame_t'(shreg);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int RES       = 12,
  parameter bit MID_RESET = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_go,
  input  frame_t         frame,
  output logic [RES-1:0] in_code,
  output logic [RES-1:0] dac_code,
  output logic           pwr_down,
  output logic           ref_supply
);
  localparam logic [RES-1:0] RESET_CODE =
    MID_RESET ? (RES'(1) << (RES-1)) : '0;

  logic [RES-1:0] new_code;
  logic           unused_bits;

  assign new_code    = frame.word[WORD_BITS-1 -: RES];
  assign unused_bits = ^{frame.pad, frame.word[WORD_BITS-RES-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_code    <= RESET_CODE;
      dac_code   <= RESET_CODE;
      pwr_down   <= 1'b0;
      ref_supply <= 1'b0;
    end else if (exec_go) begin
      case (frame.op)
        OP_LOAD_IN: in_code <= new_code;
        OP_COMMIT: begin
          dac_code <= in_code;
          pwr_down <= 1'b0;
        end
        OP_LOAD_BOTH: begin
          in_code  <= new_code;
          dac_code <= new_code;
          pwr_down <= 1'b0;
        end
        OP_SLEEP:   pwr_down   <= 1'b1;
        OP_REF_INT: ref_supply <= 1'b0;
        OP_REF_SUP: ref_supply <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import sdac_pkg::*;
#(
  parameter int RES         = 12,
  parameter bit MID_RESET   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spi_csn,
  input  logic           spi_sck,
  input  logic           spi_sdi,
  output logic [RES-1:0] dac_code,
  output logic           pwr_down,
  output logic           ref_supply
);
  logic [2:0]     pins_s;
  frame_t         frame;
  logic           exec_go;
  logic [RES-1:0] in_code;

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_csn, spi_sck, spi_sdi}), .q(pins_s)
  );

  sdac_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .csn_s(pins_s[2]), .sck_s(pins_s[1]), .sdi_s(pins_s[0]),
    .frame(frame), .exec_go(exec_go)
  );

  sdac_regs #(.RES(RES), .MID_RESET(MID_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .exec_go(exec_go), .frame(frame),
    .in_code(in_code), .dac_code(dac_code),
    .pwr_down(pwr_down), .ref_supply(ref_supply)
  );
endmodule

// File: rtl/serial_dac_frontend_chk.sv
module serial_dac_frontend_chk #(
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           exec_go,
  input logic [RES-1:0] in_code,
  input logic [RES-1:0] dac_code,
  input logic           pwr_down,
  input logic           ref_supply
);
  // R8
  quiet_without_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(exec_go) |-> ($stable(dac_code) && $stable(pwr_down) &&
                         $stable(ref_supply) && $stable(in_code)));

  // R5
  sleep_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> ($stable(dac_code) && $stable(in_code)));

  // R3
  wake_matches_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> (dac_code == in_code));

  // R6
  ref_change_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_supply) |-> ($stable(pwr_down) && $stable(dac_code) && $stable(in_code)));

  // R2
  dac_move_only_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_code)) |-> (dac_code == in_code && !pwr_down));
endmodule

bind serial_dac_frontend serial_dac_frontend_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_go(exec_go), .in_code(in_code),
  .dac_code(dac_code), .pwr_down(pwr_down), .ref_supply(ref_supply)
);

// File: tb/serial_dac_frontend_test.sv
`timescale 1ns/1ps
module serial_dac_frontend_test;
  localparam int RES = 12;
  localparam bit MID = 1'b1;
  localparam logic [RES-1:0] RST_CODE = MID ? (RES'(1) << (RES-1)) : '0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [RES-1:0] dac_code;
  logic pwr_down, ref_supply;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [RES-1:0] m_in, m_dac;
  logic m_pd, m_ref;

  always #2.5 clk = ~clk;

  serial_dac_frontend #(.RES(RES), .MID_RESET(MID)) uut (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck), .spi_sdi(sdi),
    .dac_code(dac_code), .pwr_down(pwr_down), .ref_supply(ref_supply)
  );

  function automatic logic [23:0] mk(input logic [3:0] op, input logic [15:0] w);
    return {op, 4'hA, w};
  endfunction

  function automatic string tag_of(input logic [3:0] op, input int n);
    if (n != 24 && n != 32) return "R8";
    case (op)
      4'h0: return "R2";
      4'h1: return "R3";
      4'h3: return "R4";
      4'h4: return "R5";
      4'h6, 4'h7: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [31:0] bits, input int n);
    logic [23:0] f;
    logic [RES-1:0] c;
    if (n != 24 && n != 32) return;
    f = bits[23:0];
    c = f[15 -: RES];
    case (f[23:20])
      4'h0: m_in = c;
      4'h1: begin m_dac = m_in; m_pd = 0; end
      4'h3: begin m_in = c; m_dac = c; m_pd = 0; end
      4'h4: m_pd = 1;
      4'h6: m_ref = 0;
      4'h7: m_ref = 1;
      default: ;
    endcase
  endtask

  task automatic check(input string req);
    n_checks++;
    if (dac_code !== m_dac || pwr_down !== m_pd || ref_supply !== m_ref) begin
      n_fail++;
      $display("FAIL %s: got code=%h pd=%b ref=%b, expected code=%h pd=%b ref=%b",
               req, dac_code, pwr_down, ref_supply, m_dac, m_pd, m_ref);
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n, input bit idle_hi, input string req);
    sck = idle_hi;
    #20 csn = 1'b0;
    #40;
    for (int i = n - 1; i >= 0; i--) begin
      if (idle_hi) begin
        sck = 1'b0; sdi = bits[i]; #20 sck = 1'b1; #20;
      end else begin
        sdi = bits[i]; #20 sck = 1'b1; #20 sck = 1'b0;
      end
    end
    #20 csn = 1'b1;
    #60;
    model(bits, n);
    check(req);
  endtask

  initial begin
    m_in = RST_CODE; m_dac = RST_CODE; m_pd = 0; m_ref = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1");

    // R2 and R10: write, lower padding bits set
    send({8'h0, mk(4'h0, 16'hABCF)}, 24, 0, "R2_R10");
    send({8'h0, mk(4'h1, 16'h1230)}, 24, 0, "R3");
    send({8'h0, mk(4'h4, 16'hFFFF)}, 24, 1, "R5");
    send({8'h0, mk(4'h0, 16'h555F)}, 24, 0, "R2");
    send({8'h0, mk(4'h1, 16'h0000)}, 24, 0, "R3");
    send({8'h0, mk(4'h3, 16'h7E1F)}, 24, 0, "R4");
    send({8'h0, mk(4'h7, 16'hFFFF)}, 24, 0, "R6");
    send({8'h0, mk(4'h6, 16'h0000)}, 24, 1, "R6");
    // R7: 32-bit frame, leading byte 0xA5 must be dropped
    send({8'hA5, mk(4'h3, 16'h1230)}, 32, 1, "R7");
    send({8'h3F, mk(4'h7, 16'h0000)}, 32, 0, "R7");
    // R8: wrong lengths are discarded
    send({8'h0, mk(4'h3, 16'hFFF0)} >> 1, 23, 0, "R8");
    send({7'h0, mk(4'h3, 16'hEEE0), 1'b1}, 25, 0, "R8");
    send({1'b0, mk(4'h3, 16'hDDD0), 7'h0}, 31, 1, "R8");
    send(32'h0000_3FF0, 16, 0, "R8");
    // R9: reserved codes
    send({8'h0, mk(4'h2, 16'hBBB0)}, 24, 0, "R9");
    send({8'h0, mk(4'h5, 16'hCCC0)}, 24, 0, "R9");
    send({8'h0, mk(4'hF, 16'h9990)}, 24, 0, "R9");
    // R8: stray clock edges with select high are not counted
    for (int k = 0; k < 5; k++) begin #20 sck = 1'b1; #20 sck = 1'b0; end
    send({8'h0, mk(4'h3, 16'h4560)}, 24, 0, "R8");

    for (int k = 0; k < 70; k++) begin
      logic [31:0] b;
      int n;
      int sel;
      b = $urandom(k * 7 + 11);
      sel = $urandom % 8;
      n = (sel < 4) ? 24 : (sel < 7) ? 32 : 20 + ($urandom % 14);
      if ($urandom % 2 == 0) b[23:20] = 4'h4;
      else if ($urandom % 3 == 0) b[23:20] = 4'h1;
      send(b, n, $urandom % 2, tag_of(b[23:20], n));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule